// File: doc/BRIEF.md
# Page Write Buffer and Write-Cycle Controller

This block sits behind the serial front end of a byte-addressed nonvolatile memory. Once a write transfer has delivered its two address bytes, the front end hands the block the full start address. It then hands over each received data byte with a one-cycle strobe. The block keeps the page number fixed and places each byte in a page-sized staging buffer at the current in-page offset. The offset then advances by one and wraps inside the page. A mask records which offsets were filled during the transfer.

When the front end reports a STOP, the block decides whether to commit. A commit needs three things: the STOP fell in the clock that directly follows an acknowledge, the write-protect input is low, and at least one byte was buffered. If any condition fails, the staged bytes are thrown away and the block is ready again at once. On a commit, a write-cycle timer raises busy for a parameterised number of clock cycles, which models the internal program time. During the first cycles of that window, the block steps once through every page offset in ascending order and issues one array write for each offset that was filled. While busy is high, the block ignores every input, so the front end can refuse to acknowledge polling addresses.

Top module: `pgwr_ctrl`

## Requirements
- R1: After reset, busy_o is low and mem_we_o is low.
- R2: The first data byte after an address load is staged at the loaded address. Each further byte goes to the next offset. On commit, the writes reach the array at address {page, offset}, one per cycle, in ascending offset order.
- R3: The offset is the low log2(PAGE_BYTES) address bits. Bytes past the last offset wrap to offset 0 of the same page and never change the page bits. A later byte at the same offset replaces the earlier one.
- R4: Only offsets that received a byte in the current transfer are written. No write is issued for any other offset of the page.
- R5: A STOP with stop_on_ack_i low starts no write cycle and discards the staged bytes. A later committing STOP with no new bytes therefore writes nothing.
- R6: A STOP while wp_i is high starts no write cycle and produces no array write. busy_o stays low, and the staged bytes are discarded.
- R7: A committing STOP raises busy_o in the next cycle. busy_o then stays high for exactly max(WC_CYCLES, PAGE_BYTES) cycles. Array writes occur only while busy_o is high.
- R8: While busy_o is high, address loads, data strobes, START and STOP have no effect. They neither shorten nor restart the busy window, they change no array write, and they stage no data.
- R9: A STOP after an address phase with no data bytes (a dummy write) starts no write cycle.
- R10: A START seen while idle discards the staged bytes. A following committing STOP then writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_addr_i | input | ADDR_W | Address from the front end's address phase |
| addr_load_i | input | 1 | Loads start_addr_i and clears the staged mask |
| start_i | input | 1 | START condition seen on the bus |
| byte_vld_i | input | 1 | One-cycle strobe: a data byte was received |
| byte_data_i | input | 8 | Received data byte |
| stop_i | input | 1 | STOP condition seen on the bus |
| stop_on_ack_i | input | 1 | STOP fell in the clock right after an acknowledge |
| wp_i | input | 1 | Write protect, high blocks the commit |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | 8 | Array write data |
| busy_o | output | 1 | Write cycle in progress, inputs disabled |

## Verification
The bench builds the block with a 15-bit address, a 64-byte page and WC_CYCLES set to 80. The real page size keeps wrap-around and full-page overwrite reachable in a single transfer. The short timer lets dozens of complete write cycles run, each timed end to end, and it still leaves room for input traffic inside the busy window. Random transfers vary the start offset, the byte count (from none to more than a page), the STOP position and write protect. Directed cases cover byte write, wrap, sparse offsets, START discard and inputs sent during busy.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    typedef logic [7:0] byte_t;

    // Width of a counter that must hold the value n
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/pgwr_buf.sv
module pgwr_buf
    import pgwr_pkg::*;
#(
    parameter int PAGE_BYTES = 64,
    localparam int OFF_W = $clog2(PAGE_BYTES)
) (
    input  logic             clk_i,
    input  logic             wr_en_i,
    input  logic [OFF_W-1:0] wr_idx_i,
    input  byte_t            wr_data_i,
    input  logic [OFF_W-1:0] rd_idx_i,
    output byte_t            rd_data_o
);

    byte_t store_d [PAGE_BYTES];
    byte_t store_q [PAGE_BYTES];

    always_comb begin
        store_d = store_q;
        if (wr_en_i) begin
            store_d[wr_idx_i] = wr_data_i;
        end
    end

    // Data storage only: validity is tracked by the mask in the controller
    always_ff @(posedge clk_i) begin
        store_q <= store_d;
    end

    assign rd_data_o = store_q[rd_idx_i];

endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
    parameter int CYCLES = 500000,
    localparam int CNT_W = pgwr_pkg::cnt_width(CYCLES)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    output logic busy_o
);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.busy) begin
            if (tmr_q.cnt == CNT_W'(1)) begin
                tmr_d.busy = 1'b0;
            end
            tmr_d.cnt = tmr_q.cnt - CNT_W'(1);
        end else if (load_i) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = CNT_W'(CYCLES);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign busy_o = tmr_q.busy;

    AST_LOAD_ARMS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && !tmr_q.busy) |=> (tmr_q.busy && tmr_q.cnt == CNT_W'(CYCLES))) // R7
        else $error("timer did not arm on load");

    AST_BUSY_NOT_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tmr_q.busy && tmr_q.cnt != CNT_W'(1)) |=> tmr_q.busy) // R7
        else $error("busy dropped before count expired");

    AST_NO_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tmr_q.busy && load_i) |=> (tmr_q.cnt != CNT_W'(CYCLES))) // R8
        else $error("timer restarted while busy");

endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
    import pgwr_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int PAGE_BYTES = 64,
    parameter int WC_CYCLES  = 500000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              addr_load_i,
    input  logic              start_i,
    input  logic              byte_vld_i,
    input  logic [7:0]        byte_data_i,
    input  logic              stop_i,
    input  logic              stop_on_ack_i,
    input  logic              wp_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    output logic              busy_o
);

    localparam int OFF_W   = $clog2(PAGE_BYTES);
    localparam int PG_W    = ADDR_W - OFF_W;
    // The busy window always covers the full offset scan
    localparam int BUSY_CY = (WC_CYCLES > PAGE_BYTES) ? WC_CYCLES : PAGE_BYTES;

    typedef struct packed {
        logic [PG_W-1:0]       page;
        logic [OFF_W-1:0]      off;
        logic [PAGE_BYTES-1:0] mask;
        logic                  scanning;
        logic [OFF_W-1:0]      scan_idx;
    } ctl_t;

    ctl_t  ctl_d, ctl_q;
    logic  buf_we;
    logic  commit;
    logic  busy;
    byte_t rd_byte;

    always_comb begin
        ctl_d  = ctl_q;
        buf_we = 1'b0;
        commit = 1'b0;
        if (!busy) begin
            // Event priority: address load, START, STOP, data byte
            if (addr_load_i) begin
                {ctl_d.page, ctl_d.off} = start_addr_i;
                ctl_d.mask = '0;
            end else if (start_i) begin
                ctl_d.mask = '0;
            end else if (stop_i) begin
                if (stop_on_ack_i && !wp_i && (|ctl_q.mask)) begin
                    commit         = 1'b1;
                    ctl_d.scanning = 1'b1;
                    ctl_d.scan_idx = '0;
                end else begin
                    ctl_d.mask = '0;
                end
            end else if (byte_vld_i) begin
                buf_we                = 1'b1;
                ctl_d.mask[ctl_q.off] = 1'b1;
                ctl_d.off             = ctl_q.off + OFF_W'(1);
            end
        end else if (ctl_q.scanning) begin
            ctl_d.scan_idx = ctl_q.scan_idx + OFF_W'(1);
            if (ctl_q.scan_idx == OFF_W'(PAGE_BYTES - 1)) begin
                ctl_d.scanning = 1'b0;
                ctl_d.mask     = '0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    pgwr_buf #(
        .PAGE_BYTES(PAGE_BYTES)
    ) buf_i (
        .clk_i    (clk_i),
        .wr_en_i  (buf_we),
        .wr_idx_i (ctl_q.off),
        .wr_data_i(byte_data_i),
        .rd_idx_i (ctl_q.scan_idx),
        .rd_data_o(rd_byte)
    );

    pgwr_timer #(
        .CYCLES(BUSY_CY)
    ) tmr_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .load_i(commit),
        .busy_o(busy)
    );

    assign mem_we_o    = ctl_q.scanning && ctl_q.mask[ctl_q.scan_idx];
    assign mem_addr_o  = {ctl_q.page, ctl_q.scan_idx};
    assign mem_wdata_o = rd_byte;
    assign busy_o      = busy;

    AST_WRITE_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |-> busy_o) // R7
        else $error("array write outside busy window");

    AST_WP_HOLDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_i && wp_i && !busy_o) |=> !busy_o) // R6
        else $error("write cycle started under write protect");

    AST_LATE_STOP_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_i && !stop_on_ack_i && !busy_o) |=> (!busy_o && ctl_q.mask == '0)) // R5
        else $error("misplaced STOP kept data or started a cycle");

    AST_PAGE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> $stable(ctl_q.page)) // R8
        else $error("page changed during write cycle");

    AST_WRITES_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.scanning && $past(ctl_q.scanning)) |->
            (ctl_q.scan_idx == $past(ctl_q.scan_idx) + OFF_W'(1))) // R2
        else $error("offset scan not ascending");

endmodule

// File: tb/pgwr_ctrl_tb_top.sv
module pgwr_ctrl_tb_top;

    localparam int AW = 15;
    localparam int PB = 64;
    localparam int WC = 80;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] saddr = '0;
    logic          addr_ld = 1'b0;
    logic          st = 1'b0;
    logic          bv = 1'b0;
    logic [7:0]    bd = '0;
    logic          sp = 1'b0;
    logic          spa = 1'b0;
    logic          wp = 1'b0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          busy;

    always #10 clk = ~clk;

    pgwr_ctrl #(.ADDR_W(AW), .PAGE_BYTES(PB), .WC_CYCLES(WC)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_addr_i(saddr), .addr_load_i(addr_ld),
        .start_i(st), .byte_vld_i(bv), .byte_data_i(bd), .stop_i(sp),
        .stop_on_ack_i(spa), .wp_i(wp), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .busy_o(busy)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Bench model of the staged page
    logic [7:0] eb [PB];
    bit         em [PB];
    int         ep, eo;
    bit         mdl_on = 1'b1;

    logic [AW-1:0] got_a [$];
    logic [7:0]    got_d [$];
    int            busy_seen = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                got_a.push_back(mem_addr);
                got_d.push_back(mem_wdata);
            end
            if (busy) busy_seen++;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic void model_clear();
        for (int i = 0; i < PB; i++) em[i] = 1'b0;
    endfunction

    function automatic int model_count();
        int c = 0;
        for (int i = 0; i < PB; i++) if (em[i]) c++;
        return c;
    endfunction

    task automatic do_addr(input int a);
        addr_ld = 1'b1; saddr = AW'(a);
        @(negedge clk);
        addr_ld = 1'b0;
        if (mdl_on) begin
            ep = a / PB; eo = a % PB; model_clear();
        end
    endtask

    task automatic do_byte(input logic [7:0] d);
        bv = 1'b1; bd = d;
        @(negedge clk);
        bv = 1'b0;
        if (mdl_on) begin
            eb[eo] = d; em[eo] = 1'b1; eo = (eo + 1) % PB;
        end
    endtask

    task automatic do_start();
        st = 1'b1;
        @(negedge clk);
        st = 1'b0;
        if (mdl_on) model_clear();
    endtask

    task automatic do_stop(input bit ack, input bit w);
        sp = 1'b1; spa = ack; wp = w;
        @(negedge clk);
        sp = 1'b0; spa = 1'b0; wp = 1'b0;
    endtask

    // STOP, then compare busy window and array writes with the model
    task automatic finish_txn(input string req, input bit ack, input bit w, input bit meddle);
        bit commit;
        int k;
        commit = ack && !w && (model_count() > 0);
        got_a.delete(); got_d.delete(); busy_seen = 0;
        do_stop(ack, w);
        chk(req, "busy right after STOP", 32'(busy), 32'(commit));
        if (meddle) begin
            mdl_on = 1'b0;
            repeat (10) @(negedge clk);
            do_addr(3);
            do_byte(8'hEE);
            do_byte(8'hDD);
            do_start();
            do_stop(1'b1, 1'b0);
            mdl_on = 1'b1;
            repeat (WC - 12) @(negedge clk);
        end else begin
            repeat (WC + 4) @(negedge clk);
        end
        chk(req, "busy window length", 32'(busy_seen), commit ? 32'(WC) : 32'd0);
        chk(req, "busy low at end", 32'(busy), 32'd0);
        chk(req, "array write count", 32'(got_a.size()), commit ? 32'(model_count()) : 32'd0);
        if (commit) begin
            k = 0;
            for (int i = 0; i < PB; i++) begin
                if (em[i] && k < got_a.size()) begin
                    chk(req, "write address", 32'(got_a[k]), 32'(ep * PB + i));
                    chk(req, "write data", 32'(got_d[k]), 32'(eb[i]));
                    k++;
                end
            end
        end
        model_clear();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy after reset", 32'(busy), 32'd0);
        chk("R1", "write enable after reset", 32'(mem_we), 32'd0);

        // R2 byte write
        do_addr(16'h1234); do_byte(8'h5A);
        finish_txn("R2", 1'b1, 1'b0, 1'b0);

        // R2 short page write from mid page
        do_addr(16'h0105);
        for (int i = 0; i < 5; i++) do_byte(8'(8'h30 + i));
        finish_txn("R2", 1'b1, 1'b0, 1'b0);

        // R3 wrap past the end of page with overwrite
        do_addr(5 * PB + 60);
        for (int i = 0; i < 70; i++) do_byte(8'(i * 3 + 1));
        finish_txn("R3", 1'b1, 1'b0, 1'b0);

        // R4 sparse offsets only
        do_addr(7 * PB + 10);
        for (int i = 0; i < 3; i++) do_byte(8'(8'hA0 + i));
        finish_txn("R4", 1'b1, 1'b0, 1'b0);

        // R5 STOP not on acknowledge, then a clean STOP with nothing staged
        do_addr(9 * PB);
        for (int i = 0; i < 4; i++) do_byte(8'(8'h11 * i));
        finish_txn("R5", 1'b0, 1'b0, 1'b0);
        finish_txn("R5", 1'b1, 1'b0, 1'b0);

        // R6 write protect
        do_addr(11 * PB + 2);
        for (int i = 0; i < 6; i++) do_byte(8'(8'h70 + i));
        finish_txn("R6", 1'b1, 1'b1, 1'b0);
        finish_txn("R6", 1'b1, 1'b0, 1'b0);

        // R9 dummy write
        do_addr(16'h0444);
        finish_txn("R9", 1'b1, 1'b0, 1'b0);

        // R10 START discards staged data
        do_addr(13 * PB);
        for (int i = 0; i < 4; i++) do_byte(8'(8'hC0 + i));
        do_start();
        finish_txn("R10", 1'b1, 1'b0, 1'b0);

        // R8 inputs during busy are ignored; R7 window not restarted
        do_addr(20 * PB + 30);
        for (int i = 0; i < 5; i++) do_byte(8'(8'h90 + i));
        finish_txn("R8", 1'b1, 1'b0, 1'b1);
        finish_txn("R8", 1'b1, 1'b0, 1'b0);

        // Random transfers, R2 R3 R4 R5 R6 R7
        for (int t = 0; t < 30; t++) begin
            int a, n;
            bit ack, w;
            a   = int'($urandom % (1 << AW));
            n   = int'($urandom % 90);
            ack = ($urandom % 5) != 0;
            w   = ($urandom % 6) == 0;
            do_addr(a);
            for (int i = 0; i < n; i++) do_byte(8'($urandom));
            finish_txn("R7", ack, w, 1'b0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule